// File: doc/BRIEF.md
# Sleep-Mode Power Controller

This block holds the 8-bit power control register of a small 8-bit microcontroller and sequences its two sleep modes. Software writes the register while the CPU runs. Setting the light-sleep bit stops the CPU clock, and the oscillator, the timers and the UART keep running. Setting the deep-sleep bit also stops the oscillator, powers down the program flash and switches off brown-out detection. Hardware clears both mode bits when the core wakes.

Three reset inputs mark the kind of reset. A power-on reset is cold and sets a power-lost flag. A pin reset or a brown-out reset is warm and keeps that flag. Software can also set or clear the flag. A register bit selects how deep sleep ends. With the bit clear, the oscillator restarts when the wake source is released. With the bit set, the oscillator restarts at once and the CPU clock waits a fixed startup count. Two further bits go straight to the UART: one doubles its baud rate and one selects the frame-error meaning of its control bit. Two general flags are plain storage.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After `por_rst`, `reg_rdata` reads 8'h10, `cpu_clk_en`, `osc_en` and `bod_en` are 1, and `flash_pd` is 0.
- R2: After `pin_rst` or `bor_rst` without `por_rst`, bit 4 (power-lost flag) keeps its value and all other bits read 0.
- R3: While `cpu_clk_en` is 1, a `reg_wr` stores `reg_wdata` so that it reads back from the next cycle. The stored bits are: bit 7 baud double (driven on `uart_baud_x2`), bit 6 frame-error select (`uart_fe_sel`), bit 5 deep-sleep exit select, bit 4 power-lost flag, bits 3..2 general flags, bit 1 deep sleep, bit 0 light sleep.
- R4: Writing bit 0 = 1 with bit 1 = 0 sets `cpu_clk_en` to 0 from the next cycle. `osc_en` stays 1, `flash_pd` stays 0 and `bod_en` stays 1.
- R5: Light sleep ends one cycle after `irq_wake` is sampled high, or after any reset. `cpu_clk_en` then returns to 1 and bit 0 reads 0.
- R6: `wdt_run` is 1 while running. In light sleep it equals `wdt_idle_en`. In deep sleep it is 0.
- R7: Writing bit 1 = 1 sets, from the next cycle, `cpu_clk_en` = 0, `osc_en` = 0, `flash_pd` = 1 and `bod_en` = 0.
- R8: With bit 5 = 0, deep sleep keeps `osc_en` at 0 while `irq_wake` stays high. One cycle after `irq_wake` is sampled low again, `osc_en` and `cpu_clk_en` are 1 and bit 1 reads 0.
- R9: With bit 5 = 1, `osc_en` is 1 in the cycle after `irq_wake` is sampled high. `cpu_clk_en` stays 0 for WAKE_CNT (default 1024) further clock edges and then returns to 1 with bit 1 cleared.
- R10: If one write sets both bits 1 and 0, deep sleep is entered and bit 0 reads 0.
- R11: A `reg_wr` while `cpu_clk_en` is 0 is ignored.
- R12: `irq_wake` while running changes neither the register nor `cpu_clk_en`.
- R13: A pin reset during deep sleep ends it. Clocks, oscillator and flash return to the running state and bit 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| por_rst | input | 1 | Power-on (cold) reset, synchronous, active high |
| pin_rst | input | 1 | External pin reset (warm), synchronous, active high |
| bor_rst | input | 1 | Brown-out reset (warm), synchronous, active high |
| reg_wr | input | 1 | Register write strobe from the CPU |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_wake | input | 1 | An enabled interrupt is pending (level) |
| wdt_idle_en | input | 1 | Let the watchdog run during light sleep |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_en | output | 1 | Oscillator enable request |
| flash_pd | output | 1 | Flash power-down request |
| bod_en | output | 1 | Brown-out detector enable |
| wdt_run | output | 1 | Watchdog clock enable |
| uart_baud_x2 | output | 1 | UART baud-rate doubling |
| uart_fe_sel | output | 1 | UART frame-error select |

## Verification
The register write and the mode decode can fall in the same cycle. This happens when a single write sets both sleep bits. The bench provokes it with the value 8'h03 and requires that only deep sleep starts and that the light-sleep bit reads 0. A warm reset can also coincide with an active sleep mode. The bench drives a pin reset during light sleep and during deep sleep. It judges the outcome by the clock and oscillator outputs and by the power-lost flag read back afterwards.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef struct packed {
        logic baud_x2;
        logic fe_sel;
        logic pd_timed;
        logic pwr_lost;
        logic gflag1;
        logic gflag0;
        logic deep;
        logic light;
    } pmc_ctl_t;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_LIGHT,
        ST_DEEP,
        ST_DEEP_HOLD,
        ST_DEEP_TIMED
    } pmc_state_e;

    localparam pmc_ctl_t CTL_COLD = '{pwr_lost: 1'b1, default: 1'b0};

    function automatic logic in_deep(input pmc_state_e s);
        return (s == ST_DEEP) || (s == ST_DEEP_HOLD) || (s == ST_DEEP_TIMED);
    endfunction

    function automatic pmc_ctl_t warm_value(input pmc_ctl_t c);
        pmc_ctl_t w;
        w = '0;
        w.pwr_lost = c.pwr_lost;
        return w;
    endfunction

endpackage

// File: rtl/pmc_ctl_reg.sv
module pmc_ctl_reg
    import pwr_mode_pkg::*;
(
    input  logic     clk,
    input  logic     por_rst,
    input  logic     warm_rst,
    input  logic     wr_ok,
    input  logic [7:0] wdata,
    input  logic     wake_clr,
    output pmc_ctl_t ctl,
    output logic     enter_deep,
    output logic     enter_light
);
    pmc_ctl_t ctl_q;
    pmc_ctl_t wval;

    always_comb begin
        wval = pmc_ctl_t'(wdata);
        if (wval.deep) wval.light = 1'b0;
    end

    assign enter_deep  = wr_ok && wval.deep;
    assign enter_light = wr_ok && wval.light;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            ctl_q <= CTL_COLD;
        end else if (warm_rst) begin
            ctl_q <= warm_value(ctl_q);
        end else if (wr_ok) begin
            ctl_q <= wval;
        end else if (wake_clr) begin
            ctl_q.deep  <= 1'b0;
            ctl_q.light <= 1'b0;
        end
    end

    assign ctl = ctl_q;

    p_por_value_r1: assert property (@(posedge clk) por_rst |=> (ctl_q == CTL_COLD));
    p_pwr_lost_kept_r2: assert property (@(posedge clk) disable iff (por_rst)
        warm_rst |=> (ctl_q.pwr_lost == $past(ctl_q.pwr_lost)));
    p_modes_exclusive_r10: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        $onehot0({ctl_q.deep, ctl_q.light}));
    p_frozen_asleep_r11: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        (!wr_ok && !wake_clr) |=> $stable(ctl_q));
endmodule

// File: rtl/pmc_wake_timer.sv
module pmc_wake_timer #(
    parameter int WAKE_CNT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(WAKE_CNT + 1);
    localparam logic [CNT_W-1:0] START = CNT_W'(WAKE_CNT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (load)                    cnt_q <= START;
        else if (run && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign done = run && (cnt_q == '0);

    p_timer_bound_r9: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= START));
endmodule

// File: rtl/pmc_sequencer.sv
module pmc_sequencer
    import pwr_mode_pkg::*;
#(
    parameter int WAKE_CNT = 1024
) (
    input  logic clk,
    input  logic any_rst,
    input  logic enter_deep,
    input  logic enter_light,
    input  logic timed_exit,
    input  logic irq_wake,
    input  logic wdt_idle_en,
    output logic wake_clr,
    output logic cpu_clk_en,
    output logic osc_en,
    output logic flash_pd,
    output logic wdt_run
);
    pmc_state_e state_q, state_d;
    logic tmr_load, tmr_done;

    pmc_wake_timer #(.WAKE_CNT(WAKE_CNT)) i_timer (
        .clk  (clk),
        .rst  (any_rst),
        .load (tmr_load),
        .run  (state_q == ST_DEEP_TIMED),
        .done (tmr_done)
    );

    always_comb begin
        state_d  = state_q;
        wake_clr = 1'b0;
        tmr_load = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (enter_deep)       state_d = ST_DEEP;
                else if (enter_light) state_d = ST_LIGHT;
            end
            ST_LIGHT: begin
                if (irq_wake) begin
                    state_d  = ST_RUN;
                    wake_clr = 1'b1;
                end
            end
            ST_DEEP: begin
                if (irq_wake) begin
                    if (timed_exit) begin
                        state_d  = ST_DEEP_TIMED;
                        tmr_load = 1'b1;
                    end else begin
                        state_d  = ST_DEEP_HOLD;
                    end
                end
            end
            ST_DEEP_HOLD: begin
                if (!irq_wake) begin
                    state_d  = ST_RUN;
                    wake_clr = 1'b1;
                end
            end
            ST_DEEP_TIMED: begin
                if (tmr_done) begin
                    state_d  = ST_RUN;
                    wake_clr = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (any_rst) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    assign cpu_clk_en = (state_q == ST_RUN);
    assign osc_en     = !((state_q == ST_DEEP) || (state_q == ST_DEEP_HOLD));
    assign flash_pd   = in_deep(state_q);
    assign wdt_run    = (state_q == ST_RUN) || ((state_q == ST_LIGHT) && wdt_idle_en);

    p_hold_osc_off_r8: assert property (@(posedge clk) disable iff (any_rst)
        ((state_q == ST_DEEP_HOLD) && irq_wake) |=> !osc_en);
    p_light_keeps_osc_r4: assert property (@(posedge clk) disable iff (any_rst)
        enter_light && !enter_deep && cpu_clk_en |=> (osc_en && !flash_pd));
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
    import pwr_mode_pkg::*;
#(
    parameter int WAKE_CNT = 1024
) (
    input  logic       clk,
    input  logic       por_rst,
    input  logic       pin_rst,
    input  logic       bor_rst,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_wake,
    input  logic       wdt_idle_en,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic       flash_pd,
    output logic       bod_en,
    output logic       wdt_run,
    output logic       uart_baud_x2,
    output logic       uart_fe_sel
);
    pmc_ctl_t ctl;
    logic any_rst, warm_rst, wr_ok, wake_clr, enter_deep, enter_light;

    assign warm_rst = pin_rst || bor_rst;
    assign any_rst  = por_rst || warm_rst;
    assign wr_ok    = reg_wr && cpu_clk_en;

    pmc_ctl_reg i_reg (
        .clk         (clk),
        .por_rst     (por_rst),
        .warm_rst    (warm_rst),
        .wr_ok       (wr_ok),
        .wdata       (reg_wdata),
        .wake_clr    (wake_clr),
        .ctl         (ctl),
        .enter_deep  (enter_deep),
        .enter_light (enter_light)
    );

    pmc_sequencer #(.WAKE_CNT(WAKE_CNT)) i_seq (
        .clk         (clk),
        .any_rst     (any_rst),
        .enter_deep  (enter_deep),
        .enter_light (enter_light),
        .timed_exit  (ctl.pd_timed),
        .irq_wake    (irq_wake),
        .wdt_idle_en (wdt_idle_en),
        .wake_clr    (wake_clr),
        .cpu_clk_en  (cpu_clk_en),
        .osc_en      (osc_en),
        .flash_pd    (flash_pd),
        .wdt_run     (wdt_run)
    );

    assign reg_rdata    = ctl;
    assign bod_en       = !flash_pd;
    assign uart_baud_x2 = ctl.baud_x2;
    assign uart_fe_sel  = ctl.fe_sel;

    p_wake_clears_modes_r5: assert property (@(posedge clk) disable iff (any_rst)
        $rose(cpu_clk_en) |-> (reg_rdata[1:0] == 2'b00));
    p_irq_no_effect_run_r12: assert property (@(posedge clk) disable iff (any_rst)
        (cpu_clk_en && !reg_wr) |=> cpu_clk_en);
    p_deep_outputs_r7: assert property (@(posedge clk) disable iff (any_rst)
        (cpu_clk_en && reg_wr && reg_wdata[1]) |=> (flash_pd && !osc_en && !bod_en));
endmodule

// File: tb/test_pwr_mode_ctl.sv
module test_pwr_mode_ctl;
    localparam int WAKE_CNT = 1024;

    logic clk = 1'b0;
    logic por_rst = 1'b1, pin_rst = 1'b0, bor_rst = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq_wake = 1'b0, wdt_idle_en = 1'b0;
    logic cpu_clk_en, osc_en, flash_pd, bod_en, wdt_run, uart_baud_x2, uart_fe_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwr_mode_ctl #(.WAKE_CNT(WAKE_CNT)) i_pwr_mode_ctl (
        .clk(clk), .por_rst(por_rst), .pin_rst(pin_rst), .bor_rst(bor_rst),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_wake(irq_wake), .wdt_idle_en(wdt_idle_en),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .flash_pd(flash_pd),
        .bod_en(bod_en), .wdt_run(wdt_run),
        .uart_baud_x2(uart_baud_x2), .uart_fe_sel(uart_fe_sel)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic t_cold_reset;
        por_rst = 1'b1; step(2); por_rst = 1'b0;
        chk("R1 rdata", reg_rdata, 8'h10);
        chk("R1 clocks", {4'b0, cpu_clk_en, osc_en, bod_en, flash_pd}, 8'h0E);
    endtask

    task automatic t_readwrite;
        wr(8'hCC);
        chk("R3 rdata CC", reg_rdata, 8'hCC);
        chk("R3 uart bits", {6'b0, uart_baud_x2, uart_fe_sel}, 8'h03);
        wr(8'h3C);
        chk("R3 rdata 3C", reg_rdata, 8'h3C);
        chk("R3 uart clear", {6'b0, uart_baud_x2, uart_fe_sel}, 8'h00);
    endtask

    task automatic t_warm_reset;
        pin_rst = 1'b1; step(1); pin_rst = 1'b0;
        chk("R2 pin keeps flag 1", reg_rdata, 8'h10);
        wr(8'h08);
        bor_rst = 1'b1; step(1); bor_rst = 1'b0;
        chk("R2 bor keeps flag 0", reg_rdata, 8'h00);
    endtask

    task automatic t_light;
        wdt_idle_en = 1'b1;
        wr(8'h01);
        chk("R4 light entry", {4'b0, cpu_clk_en, osc_en, flash_pd, bod_en}, 8'h05);
        chk("R4 rdata", reg_rdata, 8'h01);
        chk("R6 wdt light en", {7'b0, wdt_run}, 8'h01);
        wdt_idle_en = 1'b0; #1;
        chk("R6 wdt light dis", {7'b0, wdt_run}, 8'h00);
        wr(8'hFF);
        chk("R11 write ignored", reg_rdata, 8'h01);
        irq_wake = 1'b1; step(1); irq_wake = 1'b0;
        chk("R5 irq wake clk", {7'b0, cpu_clk_en}, 8'h01);
        chk("R5 light cleared", reg_rdata, 8'h00);
        chk("R6 wdt run", {7'b0, wdt_run}, 8'h01);
    endtask

    task automatic t_irq_in_run;
        wr(8'h0C);
        irq_wake = 1'b1; step(3); irq_wake = 1'b0;
        chk("R12 clk stays", {7'b0, cpu_clk_en}, 8'h01);
        chk("R12 reg stays", reg_rdata, 8'h0C);
    endtask

    task automatic t_light_reset;
        wr(8'h01);
        chk("R4 asleep", {7'b0, cpu_clk_en}, 8'h00);
        pin_rst = 1'b1; step(1); pin_rst = 1'b0;
        chk("R5 reset wake", {7'b0, cpu_clk_en}, 8'h01);
        chk("R5 reset rdata", reg_rdata, 8'h00);
    endtask

    task automatic t_deep_ext;
        wr(8'h02);
        chk("R7 deep entry", {4'b0, cpu_clk_en, osc_en, flash_pd, bod_en}, 8'h02);
        chk("R6 wdt deep", {7'b0, wdt_run}, 8'h00);
        irq_wake = 1'b1; step(3);
        chk("R8 held osc", {6'b0, osc_en, cpu_clk_en}, 8'h00);
        irq_wake = 1'b0; step(1);
        chk("R8 release", {5'b0, osc_en, cpu_clk_en, flash_pd}, 8'h06);
        chk("R8 rdata", reg_rdata, 8'h00);
    endtask

    task automatic t_deep_timed;
        wr(8'h22);
        chk("R9 entry rdata", reg_rdata, 8'h22);
        irq_wake = 1'b1; step(1); irq_wake = 1'b0;
        chk("R9 osc on", {6'b0, osc_en, cpu_clk_en}, 8'h02);
        step(WAKE_CNT - 1);
        chk("R9 still waiting", {6'b0, cpu_clk_en, flash_pd}, 8'h01);
        step(1);
        chk("R9 clock back", {6'b0, cpu_clk_en, flash_pd}, 8'h02);
        chk("R9 rdata", reg_rdata, 8'h20);
    endtask

    task automatic t_both_bits;
        wr(8'h03);
        chk("R10 rdata", reg_rdata, 8'h02);
        chk("R10 deep", {6'b0, osc_en, flash_pd}, 8'h01);
        irq_wake = 1'b1; step(1); irq_wake = 1'b0; step(1);
        chk("R10 exit", {7'b0, cpu_clk_en}, 8'h01);
    endtask

    task automatic t_deep_reset;
        wr(8'h12);
        pin_rst = 1'b1; step(1); pin_rst = 1'b0;
        chk("R13 outputs", {4'b0, cpu_clk_en, osc_en, flash_pd, bod_en}, 8'h0D);
        chk("R13 rdata", reg_rdata, 8'h10);
    endtask

    initial begin
        fork
            begin
                t_cold_reset();
                t_readwrite();
                t_warm_reset();
                t_light();
                t_irq_in_run();
                t_light_reset();
                t_deep_ext();
                t_deep_timed();
                t_both_bits();
                t_deep_reset();
            end
            begin
                step(20000);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule